// File: doc/BRIEF.md
# Pairwise-Matrix LRU Way Tracker

This block keeps the recency order of the ways in one set of a set-associative cache and names the way that was used longest ago, so the cache can pick a replacement victim. Each time the cache touches a way, on a hit or on a fill, it pulses a strobe with that way's index. The tracker then makes that way the newest in its order. The victim is always available at the outputs, both as a one-hot vector and as a binary index.

The order is stored as a square bit matrix with one row and one column per way. Bit (i, j) is 1 when way i was used more recently than way j. The diagonal carries no information and is not stored. A reference to way i sets every bit in row i and clears every bit in column i, both on the same clock edge. The victim is the single way whose row is all zeros.

The number of ways is a parameter. The default is four. A cache with many sets places one tracker per set, outside this block.

Top module: `lru_matrix_tracker`

## Requirements
- R1: A synchronous reset loads a strict order in which way k is newer than every lower-numbered way. After a reset the victim is way 0, so `victim_idx` = 0 and `victim_onehot` = 4'b0001 for four ways.
- R2: A reference (`ref_valid` high with way `ref_way`) changes the order only on the next rising clock edge. Before that edge the outputs still show the old victim. After it, the referenced way is the newest.
- R3: `victim_idx` is the binary position of the single set bit in `victim_onehot`. Bit k of `victim_onehot` marks way k. The victim is the way whose matrix row has no set bit.
- R4: Outside reset, exactly one bit of `victim_onehot` is set and `victim_valid` is 1.
- R5: While `ref_valid` is low, the order does not change, whatever value `ref_way` carries.
- R6: A reference to the way that is already the newest leaves the whole order unchanged.
- R7: With four ways, the references 0,1,2,3,2,1,0 after a reset leave way 3 as the victim.
- R8: With two or more ways, the way named by a reference is never the victim on the cycle after that reference.
- R9: Reset takes priority over a reference presented in the same cycle.
- R10: After any sequence of references, the victim is the way whose most recent reference is the oldest. A way not referenced since reset ranks by its reset position, older than any referenced way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Reference strobe for one cycle |
| ref_way | input | IDX_W | Index of the referenced way |
| victim_onehot | output | WAYS | One-hot mark of the least recently used way |
| victim_idx | output | IDX_W | Binary index of the least recently used way |
| victim_valid | output | 1 | High when a victim is marked |

## Verification
A stimulus table runs a long reference stream after reset. The expected victims were worked out from last-use order, so a design that swapped the row-set and column-clear roles would name the newest way instead of the oldest. Directed tests target the following cases:
- A repeated reference to the newest way. A design that toggles bits, or clears the row, would disturb the later order.
- Strobe-low cycles with a moving `ref_way`. A design that ignores the strobe would reorder the ways.
- A reset that coincides with a reference. A design that gives the reference priority would report way 1 instead of way 0.
- The cycle before the update edge. A design with a combinational bypass would show the new victim too early.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Position of off-diagonal pair (row, col) in a packed vector holding
    // only the ways*(ways-1) meaningful bits, row-major, diagonal skipped.
    function automatic int pair_slot(input int ways, input int row, input int col);
        return row * (ways - 1) + ((col < row) ? col : col - 1);
    endfunction

    // Initial order: a higher-numbered way counts as more recent.
    function automatic logic boot_bit(input int row, input int col);
        return (row > col);
    endfunction

endpackage

// File: rtl/lru_pair_matrix.sv
module lru_pair_matrix
    import lru_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_en,
    input  logic [IDX_W-1:0]            upd_way,
    output logic [WAYS-1:0][WAYS-1:0]   rows_o
);

    localparam int PAIRS = WAYS * (WAYS - 1);
    localparam logic [IDX_W:0] WAYS_L = (IDX_W + 1)'(WAYS);

    typedef struct packed {
        logic [PAIRS-1:0] bits;
    } order_t;

    order_t ord_d, ord_q;
    logic   upd_ok;

    assign upd_ok = upd_en && ({1'b0, upd_way} < WAYS_L);

    always_comb begin
        ord_d = ord_q;
        if (rst) begin
            for (int r = 0; r < WAYS; r++) begin
                for (int c = 0; c < WAYS; c++) begin
                    if (r != c) begin
                        ord_d.bits[pair_slot(WAYS, r, c)] = boot_bit(r, c);
                    end
                end
            end
        end else if (upd_ok) begin
            for (int r = 0; r < WAYS; r++) begin
                for (int c = 0; c < WAYS; c++) begin
                    if (r != c) begin
                        if (IDX_W'(r) == upd_way) begin
                            ord_d.bits[pair_slot(WAYS, r, c)] = 1'b1;
                        end else if (IDX_W'(c) == upd_way) begin
                            ord_d.bits[pair_slot(WAYS, r, c)] = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        ord_q <= ord_d;
    end

    // Expand to a full square view; the diagonal is a constant zero.
    for (genvar r = 0; r < WAYS; r++) begin : g_row
        for (genvar c = 0; c < WAYS; c++) begin : g_col
            if (r == c) begin : g_diag
                assign rows_o[r][c] = 1'b0;
            end else begin : g_pair
                localparam int SLOT = r * (WAYS - 1) + ((c < r) ? c : c - 1);
                assign rows_o[r][c] = ord_q.bits[SLOT];
            end
        end
    end

endmodule

// File: rtl/lru_zero_row_detect.sv
module lru_zero_row_detect #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0][WAYS-1:0] rows_i,
    output logic [WAYS-1:0]           empty_o
);

    for (genvar r = 0; r < WAYS; r++) begin : g_row
        assign empty_o[r] = ~(|rows_i[r]);
    end

endmodule

// File: rtl/lru_victim_encode.sv
module lru_victim_encode #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [WAYS-1:0]  mark_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (mark_i[k]) begin
                idx_o = idx_o | IDX_W'(k);
            end
        end
    end

    assign any_o = |mark_i;

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
    parameter int WAYS  = 4,
    parameter int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_way,
    output logic [WAYS-1:0]  victim_onehot,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_valid
);

    logic [WAYS-1:0][WAYS-1:0] rows;

    lru_pair_matrix #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W)
    ) i_matrix (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (ref_valid),
        .upd_way (ref_way),
        .rows_o  (rows)
    );

    lru_zero_row_detect #(
        .WAYS (WAYS)
    ) i_detect (
        .rows_i  (rows),
        .empty_o (victim_onehot)
    );

    lru_victim_encode #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W)
    ) i_encode (
        .mark_i (victim_onehot),
        .idx_o  (victim_idx),
        .any_o  (victim_valid)
    );

endmodule

// File: rtl/lru_tracker_checker.sv
module lru_tracker_checker #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_valid,
    input logic [IDX_W-1:0] ref_way,
    input logic [WAYS-1:0]  victim_onehot,
    input logic [IDX_W-1:0] victim_idx,
    input logic             victim_valid
);

    // R1
    boot_victim_chk: assert property (@(posedge clk)
        rst |=> (victim_idx == '0 && victim_onehot == WAYS'(1)));

    // R4
    single_victim_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(victim_onehot) == 1 && victim_valid));

    // R3
    idx_agree_chk: assert property (@(posedge clk) disable iff (rst)
        victim_onehot[victim_idx] == 1'b1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> $stable(victim_onehot));

    // R8
    fresh_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> victim_idx != $past(ref_way));

    // R6
    mru_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && $past(ref_valid) && !$past(rst) && ref_way == $past(ref_way))
            |=> $stable(victim_onehot));

endmodule

bind lru_matrix_tracker lru_tracker_checker #(
    .WAYS  (WAYS),
    .IDX_W (IDX_W)
) i_checker (
    .clk           (clk),
    .rst           (rst),
    .ref_valid     (ref_valid),
    .ref_way       (ref_way),
    .victim_onehot (victim_onehot),
    .victim_idx    (victim_idx),
    .victim_valid  (victim_valid)
);

// File: tb/test_lru_matrix_tracker.sv
module test_lru_matrix_tracker;

    localparam int WAYS  = 4;
    localparam int IDX_W = 2;
    localparam int NVEC  = 13;

    // Each entry: {referenced way, expected victim afterwards}, from reset.
    localparam logic [3:0] VEC [NVEC] = '{
        {2'd0, 2'd1}, {2'd1, 2'd2}, {2'd2, 2'd3}, {2'd3, 2'd0},
        {2'd2, 2'd0}, {2'd1, 2'd0}, {2'd0, 2'd3}, {2'd0, 2'd3},
        {2'd3, 2'd2}, {2'd2, 2'd1}, {2'd1, 2'd0}, {2'd3, 2'd0},
        {2'd0, 2'd2}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_valid = 1'b0;
    logic [IDX_W-1:0] ref_way = '0;
    logic [WAYS-1:0]  victim_onehot;
    logic [IDX_W-1:0] victim_idx;
    logic             victim_valid;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    lru_matrix_tracker #(
        .WAYS (WAYS)
    ) i_lru_matrix_tracker (
        .clk           (clk),
        .rst           (rst),
        .ref_valid     (ref_valid),
        .ref_way       (ref_way),
        .victim_onehot (victim_onehot),
        .victim_idx    (victim_idx),
        .victim_valid  (victim_valid)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_victim(input string req, input int exp);
        check_eq({req, " idx"}, int'(victim_idx), exp);
        check_eq({req, " onehot"}, int'(victim_onehot), 1 << exp);
        check_eq({req, " valid"}, int'(victim_valid), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_ref(input int way);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_way   = IDX_W'(way);
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        check_victim("R1 reset", 0);

        // R10 R2 R3 R4 R8: table walk
        for (int v = 0; v < NVEC; v++) begin
            do_ref(int'(VEC[v][3:2]));
            if (v == 6) check_victim("R7 trace 0,1,2,3,2,1,0", int'(VEC[v][1:0]));
            else        check_victim("R10 table", int'(VEC[v][1:0]));
        end

        // R5: strobe low, ref_way moving; victim stays at 2
        for (int k = 0; k < WAYS; k++) begin
            @(negedge clk);
            ref_way = IDX_W'(k);
            @(negedge clk);
            check_victim("R5 idle", 2);
        end

        // R1: reset mid-sequence restores the boot order
        do_reset();
        check_victim("R1 mid reset", 0);

        // R2: no change before the edge, change after it
        @(negedge clk);
        ref_valid = 1'b1;
        ref_way   = 2'd0;
        #1;
        check_victim("R2 before edge", 0);
        @(negedge clk);
        ref_valid = 1'b0;
        check_victim("R2 after edge", 1);

        // R6: repeated reference to the newest way; later order must match
        do_reset();
        do_ref(2);
        check_victim("R6 first", 0);
        do_ref(2);
        check_victim("R6 repeat", 0);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_way   = 2'd2;
        @(negedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        check_victim("R6 back to back", 0);
        do_ref(0);
        check_victim("R6 order a", 1);
        do_ref(1);
        check_victim("R6 order b", 3);
        do_ref(3);
        check_victim("R6 order c", 2);

        // R9: reset and reference together; reset wins
        do_ref(0);
        @(negedge clk);
        rst       = 1'b1;
        ref_valid = 1'b1;
        ref_way   = 2'd0;
        @(negedge clk);
        rst       = 1'b0;
        ref_valid = 1'b0;
        check_victim("R9 reset priority", 0);

        // R8: each way in turn is never the victim right after its reference
        for (int k = WAYS - 1; k >= 0; k--) begin
            do_ref(k);
            n_checks++;
            if (int'(victim_idx) == k) begin
                n_errors++;
                $display("FAIL R8: actual %0d expected not %0d", victim_idx, k);
            end
        end
        check_victim("R10 reverse sweep", 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule